// File: doc/BRIEF.md
# Multi-Channel ADC Window Filter Bank

This block watches the conversion results of a small multi-channel ADC and decides, once per sampling round, which of a bank of programmable windows the current set of channel values falls into. Results arrive one channel at a time. The block keeps the newest value of every channel. When every channel has reported at least once since the last evaluation, it tests all filters against that complete set of values. Each filter has, for every channel, a lower bound, an upper bound, a flag that selects an inside or an outside test, and an enable. A filter counts as a match only when all of its channels pass.

Matches are recorded in sticky per-filter status bits, which software clears by writing ones. A per-filter mask turns recorded matches into wakeup requests. A second sticky register holds interrupt sources: one per filter plus a oneshot-done source. A single interrupt line is driven from those sources whose enable bits are set. When an enabled source fires, the channel values used in that decision are frozen in a separate capture register, so they can be read later.

Top module: `adc_window_bank`

## Requirements
- R1: A sample presented with `smp_valid` high is stored as the latest value of the channel named by `smp_chan` (channel c occupies bits `c*W +: W` of `chan_latest`) after that clock edge. The other channels keep their values, and `chan_latest` does not change in a cycle without `smp_valid`.
- R2: Filters are evaluated only in the cycle after a sample completes a round, that is, after every channel has delivered at least one sample since the previous evaluation. Repeated samples of the same channel do not complete a round. New status bits become visible after the edge that follows the round-completing sample edge.
- R3: With the outside flag at 0, a channel passes when lower ≤ sample ≤ upper, with both bounds inclusive. Filter f, channel c uses `win_lo/win_hi[(f*NC+c)*W +: W]` and bit `f*NC+c` of `win_outside` and `win_en`.
- R4: With the outside flag at 1, a channel passes when sample < lower or sample > upper. A sample equal to a bound does not pass.
- R5: A filter matches only when every one of its channels passes. A channel whose enable bit is 0 never passes, so that filter cannot match.
- R6: Bit f of `filt_status` is set by a match of filter f and holds until a cycle with bit f of `filt_clr` high. When a match and a clear of the same bit fall in the same cycle, the bit stays set.
- R7: `wake_req` is the bitwise AND of `filt_status` and `wake_en`.
- R8: `intr_status` bits 0 to NF-1 are set by the matches of filters 0 to NF-1, and bit NF is set by an `oneshot_done` pulse. Sources are recorded whatever their enables say. Each bit is cleared by a 1 on the same bit of `intr_clr`, and a set wins over a clear in the same cycle.
- R9: `intr_o` is high exactly when some bit of `intr_status` is high and the same bit of `intr_en` is set.
- R10: In a cycle where an interrupt source whose enable is set is being recorded, `chan_at_intr` takes the channel values held before that edge. Otherwise it is unchanged.
- R11: After reset, all status bits, all stored channel values, the capture register and `intr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A conversion result is present this cycle |
| smp_chan | input | CW | Channel index of the result |
| smp_data | input | W | Conversion result |
| win_lo | input | NF*NC*W | Lower bounds, one per filter and channel |
| win_hi | input | NF*NC*W | Upper bounds, one per filter and channel |
| win_outside | input | NF*NC | 1 selects the outside test |
| win_en | input | NF*NC | Per filter and channel enable |
| wake_en | input | NF | Filters allowed to request a wakeup |
| intr_en | input | NF+1 | Interrupt source enables |
| oneshot_done | input | 1 | Pulse: a oneshot conversion finished |
| filt_clr | input | NF | Write-one-to-clear for filter status |
| intr_clr | input | NF+1 | Write-one-to-clear for interrupt status |
| filt_status | output | NF | Sticky filter match bits |
| wake_req | output | NF | Wakeup requests |
| intr_status | output | NF+1 | Sticky interrupt sources |
| intr_o | output | 1 | Combined interrupt |
| chan_latest | output | NC*W | Newest value of each channel |
| chan_at_intr | output | NC*W | Channel values captured at the last enabled interrupt |

## Verification
Some checks run on every cycle. Stored channel values hold steady between samples. The pending-channel mask is empty whenever an evaluation is pending. Filter status rises only in an evaluation cycle. A filter with a disabled channel never reports a match. Sticky bits never drop without a clear, and a set always lands. The capture register only moves on an enabled interrupt event. Other behaviour needs a scenario to show it: the inclusive and exclusive handling of each bound, the all-channel agreement rule, a set colliding with a clear, and whether the captured values are the ones that were actually judged.

// File: rtl/adcwf_pkg.sv
// adcwf_pkg: shared sizes and types of the ADC window filter bank.
// Assumes: all modules of the bank take their defaults from here.
package adcwf_pkg;
    localparam int unsigned NUM_FILT = 8;
    localparam int unsigned NUM_CHAN = 2;
    localparam int unsigned SAMP_W   = 10;
endpackage

// File: rtl/adcwf_sample_hold.sv
// adcwf_sample_hold: keeps the newest sample per channel and announces a
// complete round (every channel seen at least once) with a one-cycle pulse.
// Assumes: at most one sample per cycle; out-of-range channel indices are dropped.
module adcwf_sample_hold #(
    parameter int unsigned NC = adcwf_pkg::NUM_CHAN,
    parameter int unsigned W  = adcwf_pkg::SAMP_W,
    localparam int unsigned CW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [CW-1:0]   smp_chan,
    input  logic [W-1:0]    smp_data,
    output logic [NC*W-1:0] latest,
    output logic            round_done
);
    logic [NC-1:0] hit;
    logic [NC-1:0] seen_q;
    logic [NC-1:0] seen_nxt;
    logic          complete;

    // Decode which channel register this sample targets.
    always_comb begin
        hit = '0;
        if (smp_valid && (int'(smp_chan) < int'(NC)))
            hit[smp_chan] = 1'b1;
        seen_nxt = seen_q | hit;
        complete = (hit != '0) && (&seen_nxt);
    end

    // Track channels seen in the current round; clear when it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= '0;
            round_done <= 1'b0;
        end else begin
            seen_q     <= complete ? '0 : seen_nxt;
            round_done <= complete;
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_chan
        // Store the newest sample of channel c.
        always_ff @(posedge clk) begin
            if (!rst_n)
                latest[c*W +: W] <= '0;
            else if (hit[c])
                latest[c*W +: W] <= smp_data;
        end
    end

    // R2: a pending evaluation always starts a fresh round.
    p_round_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        round_done |-> (seen_q == '0));

    // R1: stored samples move only when a sample arrives.
    p_latest_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(latest));
endmodule

// File: rtl/adcwf_window_cmp.sv
// adcwf_window_cmp: combinational window tests of every filter on every
// channel; a filter matches when all its channels pass.
// Assumes: bounds and samples are unsigned and equal in width.
module adcwf_window_cmp #(
    parameter int unsigned NF = adcwf_pkg::NUM_FILT,
    parameter int unsigned NC = adcwf_pkg::NUM_CHAN,
    parameter int unsigned W  = adcwf_pkg::SAMP_W,
    localparam int unsigned NW = NF * NC
) (
    input  logic [NC*W-1:0] samples,
    input  logic [NW*W-1:0] lo,
    input  logic [NW*W-1:0] hi,
    input  logic [NW-1:0]   outside,
    input  logic [NW-1:0]   en,
    output logic [NF-1:0]   match
);
    logic [NW-1:0] pass;

    for (genvar f = 0; f < NF; f++) begin : g_filt
        for (genvar c = 0; c < NC; c++) begin : g_chan
            localparam int unsigned IX = f * NC + c;
            logic in_win;
            // Inclusive window test, then pick inside or outside sense.
            always_comb begin
                in_win   = (samples[c*W +: W] >= lo[IX*W +: W]) &&
                           (samples[c*W +: W] <= hi[IX*W +: W]);
                pass[IX] = en[IX] && (outside[IX] ? !in_win : in_win);
            end
        end
        // All channels of filter f must agree.
        assign match[f] = &pass[f*NC +: NC];
    end
endmodule

// File: rtl/adcwf_sticky_bits.sv
// adcwf_sticky_bits: vector of sticky flags with write-one-to-clear,
// where a set in the same cycle overrides the clear.
// Assumes: set and clear are single-cycle qualified by the caller.
module adcwf_sticky_bits #(
    parameter int unsigned N = adcwf_pkg::NUM_FILT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    // Update flags: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= (q & ~clr_i) | set_i;
    end

    // R6/R8: a flag never drops without its clear.
    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(q) & ~$past(clr_i)) & ~q) == '0));

    // R6/R8: an event always lands, even against a clear.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/adc_window_bank.sv
// adc_window_bank: top of the ADC window filter bank. Collects per-channel
// samples, evaluates all filters once per complete round, keeps sticky filter
// and interrupt status, masks wakeups and the interrupt, and captures the
// judged channel values on an enabled interrupt event.
// Assumes: configuration inputs are quasi-static; clears are one-cycle pulses.
module adc_window_bank #(
    parameter int unsigned NF = adcwf_pkg::NUM_FILT,
    parameter int unsigned NC = adcwf_pkg::NUM_CHAN,
    parameter int unsigned W  = adcwf_pkg::SAMP_W,
    localparam int unsigned CW = (NC > 1) ? $clog2(NC) : 1,
    localparam int unsigned NW = NF * NC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [CW-1:0]   smp_chan,
    input  logic [W-1:0]    smp_data,
    input  logic [NW*W-1:0] win_lo,
    input  logic [NW*W-1:0] win_hi,
    input  logic [NW-1:0]   win_outside,
    input  logic [NW-1:0]   win_en,
    input  logic [NF-1:0]   wake_en,
    input  logic [NF:0]     intr_en,
    input  logic            oneshot_done,
    input  logic [NF-1:0]   filt_clr,
    input  logic [NF:0]     intr_clr,
    output logic [NF-1:0]   filt_status,
    output logic [NF-1:0]   wake_req,
    output logic [NF:0]     intr_status,
    output logic            intr_o,
    output logic [NC*W-1:0] chan_latest,
    output logic [NC*W-1:0] chan_at_intr
);
    logic          round_done;
    logic [NF-1:0] match;
    logic [NF-1:0] filt_set;
    logic [NF:0]   intr_set;
    logic          cap_hit;
    logic [NF-1:0] filt_all_en;

    adcwf_sample_hold #(.NC(NC), .W(W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_chan   (smp_chan),
        .smp_data   (smp_data),
        .latest     (chan_latest),
        .round_done (round_done)
    );

    adcwf_window_cmp #(.NF(NF), .NC(NC), .W(W)) u_cmp (
        .samples (chan_latest),
        .lo      (win_lo),
        .hi      (win_hi),
        .outside (win_outside),
        .en      (win_en),
        .match   (match)
    );

    // Qualify matches with the evaluation pulse and add the oneshot source.
    always_comb begin
        filt_set = round_done ? match : '0;
        intr_set = {oneshot_done, filt_set};
        cap_hit  = (intr_set & intr_en) != '0;
    end

    adcwf_sticky_bits #(.N(NF)) u_filt_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (filt_set),
        .clr_i (filt_clr),
        .q     (filt_status)
    );

    adcwf_sticky_bits #(.N(NF + 1)) u_intr_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (intr_set),
        .clr_i (intr_clr),
        .q     (intr_status)
    );

    // Mask recorded matches into wakeups and the single interrupt line.
    assign wake_req = filt_status & wake_en;
    assign intr_o   = (intr_status & intr_en) != '0;

    // Freeze the judged channel values on an enabled interrupt event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan_at_intr <= '0;
        else if (cap_hit)
            chan_at_intr <= chan_latest;
    end

    for (genvar f = 0; f < NF; f++) begin : g_allen
        assign filt_all_en[f] = &win_en[f*NC +: NC];
    end

    // R5: a filter with any disabled channel never reports a match.
    p_disabled_nomatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match & ~filt_all_en) == '0);

    // R2: filter status only rises in an evaluation cycle.
    p_rise_on_round_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(round_done) || ((filt_status & ~$past(filt_status)) == '0)));

    // R10: capture register moves only on an enabled interrupt event.
    p_capture_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_hit |=> $stable(chan_at_intr));
endmodule

// File: tb/sim_adc_window_bank.sv
// sim_adc_window_bank: scoreboard bench. The driver applies one cycle of
// stimulus at each falling edge, advances a requirement-level model and
// queues the expected outputs; the monitor pops and compares after each rising edge.
module sim_adc_window_bank;
    localparam int NF = 8;
    localparam int NC = 2;
    localparam int W  = 10;

    typedef struct {
        logic [7:0]  fst;
        logic [7:0]  wk;
        logic [8:0]  ist;
        logic        io;
        logic [19:0] lat;
        logic [19:0] cap;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [0:0] smp_chan = '0;
    logic [9:0] smp_data = '0;
    logic [159:0] win_lo = '0;
    logic [159:0] win_hi = '0;
    logic [15:0] win_outside = '0;
    logic [15:0] win_en = '0;
    logic [7:0] wake_en = '0;
    logic [8:0] intr_en = '0;
    logic oneshot_done = 1'b0;
    logic [7:0] filt_clr = '0;
    logic [8:0] intr_clr = '0;
    logic [7:0] filt_status;
    logic [7:0] wake_req;
    logic [8:0] intr_status;
    logic intr_o;
    logic [19:0] chan_latest;
    logic [19:0] chan_at_intr;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];

    logic [7:0]  m_fst = '0;
    logic [8:0]  m_ist = '0;
    logic [19:0] m_lat = '0;
    logic [19:0] m_cap = '0;
    logic [1:0]  m_seen = '0;
    logic        m_pend = 1'b0;

    always #2.5 clk = ~clk;

    adc_window_bank u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .win_lo(win_lo), .win_hi(win_hi),
        .win_outside(win_outside), .win_en(win_en), .wake_en(wake_en),
        .intr_en(intr_en), .oneshot_done(oneshot_done), .filt_clr(filt_clr),
        .intr_clr(intr_clr), .filt_status(filt_status), .wake_req(wake_req),
        .intr_status(intr_status), .intr_o(intr_o), .chan_latest(chan_latest),
        .chan_at_intr(chan_at_intr)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_win(int f, int c, int lo, int hi, logic outs, logic en);
        int ix = f * NC + c;
        win_lo[ix*W +: W] = 10'(lo);
        win_hi[ix*W +: W] = 10'(hi);
        win_outside[ix]   = outs;
        win_en[ix]        = en;
    endtask

    // Reference match from R3, R4, R5.
    function automatic logic [7:0] mdl_match(logic [19:0] l);
        logic [7:0] m = '0;
        for (int f = 0; f < NF; f++) begin
            logic ok = 1'b1;
            for (int c = 0; c < NC; c++) begin
                int ix = f * NC + c;
                logic [9:0] s = l[c*W +: W];
                logic inw = (s >= win_lo[ix*W +: W]) && (s <= win_hi[ix*W +: W]);
                logic pc = win_en[ix] && (win_outside[ix] ? !inw : inw);
                ok = ok && pc;
            end
            m[f] = ok;
        end
        return m;
    endfunction

    // Driver: one cycle of stimulus plus the model's expected outcome.
    task automatic step(logic v, logic ch, int d, logic [7:0] fc, logic [8:0] ic,
                        logic one, string tag);
        logic [7:0] setv;
        logic [8:0] iset;
        exp_t e;
        smp_valid = v; smp_chan = ch; smp_data = 10'(d);
        filt_clr = fc; intr_clr = ic; oneshot_done = one;
        setv = m_pend ? mdl_match(m_lat) : 8'h00;
        iset = {one, setv};
        if ((iset & intr_en) != '0) m_cap = m_lat;
        m_fst = (m_fst & ~fc) | setv;
        m_ist = (m_ist & ~ic) | iset;
        m_pend = 1'b0;
        if (v) begin
            m_lat[ch*W +: W] = 10'(d);
            m_seen[ch] = 1'b1;
            if (&m_seen) begin
                m_pend = 1'b1;
                m_seen = '0;
            end
        end
        e.fst = m_fst; e.wk = m_fst & wake_en; e.ist = m_ist;
        e.io = (m_ist & intr_en) != '0; e.lat = m_lat; e.cap = m_cap; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic smp(int ch, int d, string tag);
        step(1'b1, 1'(ch), d, 8'h00, 9'h000, 1'b0, tag);
    endtask

    task automatic idle(logic [7:0] fc, logic [8:0] ic, logic one, string tag);
        step(1'b0, 1'b0, 0, fc, ic, one, tag);
    endtask

    // Monitor: compare after every rising edge, before the driver moves.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(e.tag, "filt_status",  32'(filt_status),  32'(e.fst));
                chk(e.tag, "wake_req",     32'(wake_req),     32'(e.wk));
                chk(e.tag, "intr_status",  32'(intr_status),  32'(e.ist));
                chk(e.tag, "intr_o",       32'(intr_o),       32'(e.io));
                chk(e.tag, "chan_latest",  32'(chan_latest),  32'(e.lat));
                chk(e.tag, "chan_at_intr", 32'(chan_at_intr), 32'(e.cap));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // f0 inside on both channels, f1 outside on both, f2 channel 1 disabled,
        // f3 single-point window; all others disabled.
        set_win(0, 0, 100, 200, 1'b0, 1'b1); set_win(0, 1, 50, 60, 1'b0, 1'b1);
        set_win(1, 0, 100, 200, 1'b1, 1'b1); set_win(1, 1, 300, 400, 1'b1, 1'b1);
        set_win(2, 0, 0, 1023, 1'b0, 1'b1);  set_win(2, 1, 0, 1023, 1'b0, 1'b0);
        set_win(3, 0, 150, 150, 1'b0, 1'b1); set_win(3, 1, 55, 55, 1'b0, 1'b1);
        wake_en = 8'h02;
        intr_en = 9'h101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(8'h00, 9'h000, 1'b0, "R11 reset values");
        smp(0, 150, "R1 channel 0 stored");
        smp(0, 150, "R2 repeat channel no round");
        smp(1, 55, "R1 R2 round completes");
        idle(8'h00, 9'h000, 1'b0, "R3 R5 R9 R10 inside match and capture");
        idle(8'h01, 9'h001, 1'b0, "R6 R8 write-one clear");
        smp(0, 99, "R1 channel 0 update");
        smp(1, 401, "R4 outside round");
        idle(8'h00, 9'h000, 1'b0, "R4 R7 outside match and wakeup");
        smp(0, 99, "R4 second round");
        smp(1, 401, "R4 second round end");
        idle(8'h02, 9'h002, 1'b0, "R6 R8 set beats clear");
        idle(8'hFF, 9'h1FF, 1'b0, "R6 R8 clear all");
        smp(0, 200, "R4 bound equal");
        smp(1, 400, "R4 bound equal end");
        idle(8'h00, 9'h000, 1'b0, "R3 R4 upper bound equal");
        idle(8'hFF, 9'h1FF, 1'b1, "R8 R9 R10 oneshot source");
        idle(8'h00, 9'h100, 1'b0, "R9 interrupt drops after clear");
        smp(0, 100, "R3 lower bound");
        smp(1, 50, "R3 lower bound end");
        idle(8'h00, 9'h000, 1'b0, "R3 R10 lower bound inclusive");
        idle(8'hFF, 9'h1FF, 1'b0, "R6 R8 clear all again");
        intr_en = 9'h100;
        smp(1, 55, "R2 reversed channel order");
        smp(0, 150, "R2 reversed order end");
        idle(8'h00, 9'h000, 1'b0, "R5 R8 R9 R10 disabled source no interrupt");
        idle(8'h00, 9'h000, 1'b0, "R1 R6 idle hold");
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule